// File: doc/BRIEF.md
# Complementary Gate Driver with Dead-Time Insertion

This block turns one reference waveform, typically the output of a compare channel, into two gate signals for the upper and lower switches of a half bridge. The main gate follows the reference and the complementary gate follows its inverse. Every reference transition first switches the conducting side off. The opposite side then waits a programmable number of clock cycles before it switches on, so the two switches never conduct together.

A master drive enable gates both outputs. A break input overrides everything: while it is high both gates sit at their inactive level, with no clock edge needed. It also clears the master enable, which stays cleared until it is set again through its set strobe. Each gate has its own active-level selection.

Top module: `dt_bridge_pair`

## Requirements
- R1: With the enable set and no break, the main gate is active only while the registered reference is high and the complementary gate only while it is low, once the dead time after the last transition has elapsed.
- R2: The two gates are never at their active levels in the same cycle.
- R3: If the reference is sampled high at clock edge k after being low, with dead count D, the complementary gate goes inactive right after edge k and the main gate becomes active right after edge k+D.
- R4: A falling reference transition behaves the same way with the roles swapped: main inactive right after edge k, complementary active right after edge k+D.
- R5: A reference level that lasts D or fewer sampled cycles produces no active interval on the gate it would turn on. A level lasting P > D cycles gives P-D active cycles.
- R6: With a dead count of 0 each gate follows the reference one register stage later, with no gap.
- R7: While the break input is high, both gates are at their inactive level in that same cycle.
- R8: Break clears the master enable. After break falls, both gates stay inactive until a set strobe arrives with break low.
- R9: Reset leaves the enable cleared. The set strobe turns it on and the clear strobe turns it off, with break taking priority over set. While the enable is clear both gates are inactive.
- R10: A polarity input of 1 makes that gate's active level 1, and 0 makes it 0. The inactive level is always the inverse.
- R11: The dead count is captured at each reference transition. Changing it during a dead-time window does not alter that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Reference waveform from the compare stage |
| deadCount | input | CNT_W (8) | Dead time in clock cycles, 0 = none |
| mainPolHigh | input | 1 | Main gate active level (1 = high) |
| compPolHigh | input | 1 | Complementary gate active level (1 = high) |
| enSet | input | 1 | Strobe that sets the master enable |
| enClr | input | 1 | Strobe that clears the master enable |
| brk | input | 1 | Break, active high, forces both gates inactive |
| mainGate | output | 1 | Upper switch gate signal |
| compGate | output | 1 | Lower switch gate signal |

## Verification
The hardest cases to reach from the ports are the boundary pulses whose length equals the dead count exactly, or exceeds it by one. A count rewritten in the middle of a running window is just as hard, and so is a set strobe that arrives while break is still high. The stimulus drives reference levels of lengths D-1, D and D+1 around several dead counts, including zero. It changes the count one cycle after a transition and asserts the set strobe together with break. A behavioural run-length model in the bench predicts both gates every cycle.

// File: rtl/dt_pkg.sv
package dt_pkg;
  // Strobes from the control half to the output datapath
  typedef struct packed {
    logic mainOn;  // main side may conduct (dead time elapsed, ref high)
    logic compOn;  // complementary side may conduct (dead time elapsed, ref low)
    logic drive;   // master enable set and no break
  } strobe_t;
endpackage

// File: rtl/dt_ctrl.sv
module dt_ctrl #(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 refIn,
  input  logic [CNT_W-1:0]     deadCount,
  input  logic                 brk,
  input  logic                 enSet,
  input  logic                 enClr,
  output dt_pkg::strobe_t      strb
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic             refQ;
  logic [CNT_W-1:0] cnt;
  logic             enQ;
  logic             edgeSeen;
  logic             windowDone;

  assign edgeSeen   = refIn ^ refQ;
  assign windowDone = (cnt == CNT_ZERO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refQ <= 1'b0;
      cnt  <= CNT_ZERO;
    end else begin
      refQ <= refIn;
      if (edgeSeen)
        cnt <= deadCount;
      else if (!windowDone)
        cnt <= cnt - 1'b1;
    end
  end

  // Master enable: break wins, then set, then clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      enQ <= 1'b0;
    else if (brk)
      enQ <= 1'b0;
    else if (enSet)
      enQ <= 1'b1;
    else if (enClr)
      enQ <= 1'b0;
  end

  always_comb begin
    strb.mainOn = refQ & windowDone;
    strb.compOn = ~refQ & windowDone;
    strb.drive  = enQ & ~brk;
  end

  assert_break_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    brk |=> !enQ);

  assert_dead_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    edgeSeen |=> cnt == $past(deadCount));

  assert_window_steady_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!edgeSeen && !windowDone) |=> cnt == $past(cnt) - 1'b1);

  assert_gap_after_edge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (edgeSeen && deadCount != CNT_ZERO) |=> (!strb.mainOn && !strb.compOn));
endmodule

// File: rtl/dt_outpath.sv
module dt_outpath (
  input  logic            clk,
  input  logic            rstN,
  input  dt_pkg::strobe_t strb,
  input  logic            mainPolHigh,
  input  logic            compPolHigh,
  output logic            mainGate,
  output logic            compGate
);
  logic mainAct;
  logic compAct;

  always_comb begin
    mainAct  = strb.mainOn & strb.drive;
    compAct  = strb.compOn & strb.drive;
    mainGate = mainPolHigh ? mainAct : ~mainAct;
    compGate = compPolHigh ? compAct : ~compAct;
  end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rstN)
    !((mainGate == mainPolHigh) && (compGate == compPolHigh)));

  assert_idle_inactive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.drive |-> (mainGate != mainPolHigh) && (compGate != compPolHigh));
endmodule

// File: rtl/dt_bridge_pair.sv
module dt_bridge_pair #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic [CNT_W-1:0] deadCount,
  input  logic             mainPolHigh,
  input  logic             compPolHigh,
  input  logic             enSet,
  input  logic             enClr,
  input  logic             brk,
  output logic             mainGate,
  output logic             compGate
);
  dt_pkg::strobe_t strb;

  dt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refIn     (refIn),
    .deadCount (deadCount),
    .brk       (brk),
    .enSet     (enSet),
    .enClr     (enClr),
    .strb      (strb)
  );

  dt_outpath u_out (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .mainPolHigh (mainPolHigh),
    .compPolHigh (compPolHigh),
    .mainGate    (mainGate),
    .compGate    (compGate)
  );

  assert_break_forces_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    brk |-> (mainGate != mainPolHigh) && (compGate != compPolHigh));
endmodule

// File: tb/dt_bridge_pair_test.sv
module dt_bridge_pair_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refIn = 1'b0;
  logic [7:0] deadCount = 8'd0;
  logic       mainPolHigh = 1'b1;
  logic       compPolHigh = 1'b1;
  logic       enSet = 1'b0;
  logic       enClr = 1'b0;
  logic       brk = 1'b0;
  logic       mainGate;
  logic       compGate;

  int    checks = 0;
  int    failures = 0;
  string tag = "R9";

  // Reference model state
  bit mRef = 1'b0;
  bit mEn = 1'b0;
  int runLen = 0;
  int mDead = 0;

  dt_bridge_pair uut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .deadCount(deadCount),
    .mainPolHigh(mainPolHigh), .compPolHigh(compPolHigh),
    .enSet(enSet), .enClr(enClr), .brk(brk),
    .mainGate(mainGate), .compGate(compGate)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural model: run length of the sampled level against the captured dead time
  always @(posedge clk) begin
    if (!rstN) begin
      mRef = 1'b0; runLen = 0; mDead = 0; mEn = 1'b0;
    end else begin
      if (refIn != mRef) begin
        mRef = refIn; runLen = 0; mDead = int'(deadCount);
      end else begin
        runLen++;
      end
      if (brk) mEn = 1'b0;
      else if (enSet) mEn = 1'b1;
      else if (enClr) mEn = 1'b0;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    bit live, expMainAct, expCompAct;
    live = mEn && !brk && runLen >= mDead;
    expMainAct = live && mRef;
    expCompAct = live && !mRef;
    check(tag, "mainGate", mainGate, mainPolHigh ? expMainAct : !expMainAct);
    check(tag, "compGate", compGate, compPolHigh ? expCompAct : !expCompAct);
    // R2: never both active
    check("R2", "overlap", (mainGate == mainPolHigh) && (compGate == compPolHigh), 1'b0);
    if (brk) begin // R7: break forces inactive
      check("R7", "main under break", mainGate, !mainPolHigh);
      check("R7", "comp under break", compGate, !compPolHigh);
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic pulseSet();
    enSet = 1'b1; tick(1); enSet = 1'b0;
  endtask

  task automatic level(logic v, int n);
    refIn = v; tick(n);
  endtask

  initial begin
    tick(3);
    rstN = 1'b1;
    // R9: disabled after reset, toggling ref does nothing
    tag = "R9";
    level(1, 4); level(0, 4);
    pulseSet();
    tick(3);
    // R3 / R4 with D=3
    deadCount = 8'd3;
    tag = "R3"; level(1, 10);
    tag = "R4"; level(0, 10);
    // R5: pulses of length D-1, D, D+1
    tag = "R5";
    level(1, 2); level(0, 8);
    level(1, 3); level(0, 8);
    level(1, 4); level(0, 8);
    level(0, 1); level(1, 8); level(0, 3); level(1, 8);
    // R1: steady toggling with D=2
    tag = "R1"; deadCount = 8'd2;
    for (int i = 0; i < 4; i++) begin level(1, 6); level(0, 5); end
    // R6: zero dead time, single-cycle pulses
    tag = "R6"; deadCount = 8'd0;
    level(1, 1); level(0, 1); level(1, 2); level(0, 3); level(1, 1); level(0, 4);
    // R11: count changed mid-window
    tag = "R11"; deadCount = 8'd5;
    refIn = 1'b1; tick(1); deadCount = 8'd1; tick(9);
    refIn = 1'b0; tick(1); deadCount = 8'd6; tick(9);
    // R10: polarity combinations
    tag = "R10"; deadCount = 8'd2;
    mainPolHigh = 1'b0; compPolHigh = 1'b1;
    level(1, 6); level(0, 6);
    mainPolHigh = 1'b0; compPolHigh = 1'b0;
    level(1, 6); level(0, 6);
    mainPolHigh = 1'b1; compPolHigh = 1'b0;
    level(1, 6);
    // R7: break while conducting
    tag = "R7"; brk = 1'b1; tick(3);
    // R8: enable stays clear after break, set ignored while break high
    tag = "R8"; brk = 1'b0; tick(4);
    level(0, 5);
    brk = 1'b1; enSet = 1'b1; tick(1); enSet = 1'b0; brk = 1'b0; tick(4);
    pulseSet(); tick(5);
    // R9: clear strobe
    tag = "R9"; enClr = 1'b1; tick(1); enClr = 1'b0;
    level(1, 6); level(0, 4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule